// File: doc/BRIEF.md
# Two-Socket Home Directory Controller

This block is the home-side coherence controller for memory owned by one socket of a two-socket system. Each memory line carries one directory bit, kept in memory next to the line data; a set bit says the other socket may hold a modified copy. The controller takes one read request at a time from either the local cache or the remote socket. It reads the line and its directory bit, then decides whether to grant Exclusive or Shared.

A small direct-mapped table records the state in which the local cache holds recently granted lines. When a remote read finds the local copy in Exclusive, the controller first downgrades the local copy to Shared over a snoop channel. When a remote socket is granted Exclusive while the directory bit is clear, the controller rewrites the whole line to memory with the bit set. That rewrite costs memory bandwidth. Shared grants, whether they come from a downgrade or from a shared-only hint on the request, avoid it.

Top module: `hadir_top`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o, mem_req_o and snp_valid_o are 0, and rewrite_cnt_o is 0. All local table entries read as invalid.
- R2: A local read (req_remote_i=0) of a line whose directory bit is clear is granted Exclusive (rsp_state_o=2). No memory write takes place, and the table records the line as locally Exclusive.
- R3: A remote read (req_remote_i=1) without hint, to a line the table does not hold, with the directory bit clear, is granted Exclusive. Before the response, exactly one memory write takes place with the unchanged line data and mem_wdir_o=1.
- R4: A remote read that would be granted Exclusive, to a line whose directory bit is already set, causes no memory write.
- R5: A remote read of a line the table holds in Exclusive raises one snoop with that line address before the response. It is granted Shared (rsp_state_o=1), the table entry becomes Shared, and no memory write takes place. A remote read of a locally Shared line is granted Shared with no snoop and no write.
- R6: A remote read with req_shared_i=1 is granted Shared and causes no memory write. A snoop is raised only if the local copy is Exclusive.
- R7: A local read of a line whose directory bit is set is granted Shared, and no memory write takes place.
- R8: req_ready_o stays 0 from the accepting cycle until after the one-cycle rsp_valid_o pulse. rsp_data_o equals the line data and rsp_remote_o echoes the requester. mem_req_o is held with a stable address until mem_ack_i.
- R9: The table index is the low address bits, and a lookup matches only on equal tag. A line that shares an index with a tracked line, but has a different tag, is treated as not locally held.
- R10: rewrite_cnt_o increments by one for each directory rewrite and for nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_remote_i | input | 1 | Requester: 0 local cache, 1 remote socket |
| req_addr_i | input | ADDR_W | Line address |
| req_shared_i | input | 1 | Shared-only hint |
| rsp_valid_o | output | 1 | One-cycle grant pulse |
| rsp_remote_o | output | 1 | Requester of this grant |
| rsp_state_o | output | 2 | Granted state: 1 Shared, 2 Exclusive |
| rsp_data_o | output | LINE_W | Line data |
| snp_valid_o | output | 1 | Downgrade local copy to Shared |
| snp_addr_o | output | ADDR_W | Line to downgrade |
| snp_ack_i | input | 1 | Downgrade done |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | ADDR_W | Memory line address |
| mem_wdata_o | output | LINE_W | Line data to write |
| mem_wdir_o | output | 1 | Directory bit to write |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | LINE_W | Line data read |
| mem_rdir_i | input | 1 | Directory bit read |
| rewrite_cnt_o | output | CNT_W | Directory rewrite count |

## Verification
Requests are tried from both requesters, with and without the shared hint. They hit lines whose directory bit starts set or clear, and lines the local cache holds as Exclusive, Shared, or not at all. Comparing the write and snoop counts per request shows which paths pay a rewrite and which only downgrade. A second line in the same table index with a different tag separates a tag hit from an index hit. Reset in the middle of activity shows that the table and the counter clear while memory keeps its directory bits.

// File: rtl/hadir_pkg.sv
package hadir_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2} lstate_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_SNP, ST_WR, ST_RSP} fsm_e;
  typedef struct packed {
    logic    snoop;
    logic    rewrite;
    lstate_e grant;
    logic    upd;
    lstate_e upd_st;
  } decision_t;
endpackage

// File: rtl/hadir_ltab.sv
module hadir_ltab
  import hadir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              upd_i,
  input  lstate_e           upd_st_i,
  output lstate_e           st_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = ADDR_W - IDX_W;

  lstate_e          st_q  [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = addr_i[IDX_W-1:0];
  assign tag = addr_i[ADDR_W-1:IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]  <= LS_I;
        tag_q[i] <= '0;
      end
    end else if (upd_i) begin
      st_q[idx]  <= upd_st_i;
      tag_q[idx] <= tag;
    end
  end

  assign st_o = (tag_q[idx] == tag) ? st_q[idx] : LS_I;
endmodule

// File: rtl/hadir_policy.sv
module hadir_policy
  import hadir_pkg::*;
(
  input  logic      remote_i,
  input  logic      hint_i,
  input  logic      dir_i,
  input  lstate_e   lst_i,
  output decision_t dec_o
);
  always_comb begin
    dec_o = '{snoop: 1'b0, rewrite: 1'b0, grant: LS_S, upd: 1'b0, upd_st: LS_I};
    if (!remote_i) begin
      dec_o.grant  = dir_i ? LS_S : LS_E;
      dec_o.upd    = 1'b1;
      dec_o.upd_st = dir_i ? LS_S : LS_E;
    end else if (lst_i == LS_E) begin
      // downgrade local owner, share with remote
      dec_o.snoop  = 1'b1;
      dec_o.upd    = 1'b1;
      dec_o.upd_st = LS_S;
    end else if (!hint_i && lst_i != LS_S) begin
      dec_o.grant   = LS_E;
      dec_o.rewrite = !dir_i;
    end
  end
endmodule

// File: rtl/hadir_top.sv
module hadir_top
  import hadir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINE_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_remote_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_shared_i,
  output logic              rsp_valid_o,
  output logic              rsp_remote_o,
  output logic [1:0]        rsp_state_o,
  output logic [LINE_W-1:0] rsp_data_o,
  output logic              snp_valid_o,
  output logic [ADDR_W-1:0] snp_addr_o,
  input  logic              snp_ack_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  output logic              mem_wdir_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rdata_i,
  input  logic              mem_rdir_i,
  output logic [CNT_W-1:0]  rewrite_cnt_o
);
  fsm_e              st_q, st_d;
  logic              remote_q, hint_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] data_q;
  decision_t         dec_q, dec;
  lstate_e           lst;
  logic [CNT_W-1:0]  cnt_q;
  logic              rd_done;

  assign rd_done = (st_q == ST_RD) && mem_ack_i;

  hadir_ltab #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_ltab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_q),
    .upd_i    (rd_done && dec.upd),
    .upd_st_i (dec.upd_st),
    .st_o     (lst)
  );

  hadir_policy i_policy (
    .remote_i (remote_q),
    .hint_i   (hint_q),
    .dir_i    (mem_rdir_i),
    .lst_i    (lst),
    .dec_o    (dec)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_RD;
      ST_RD:   if (mem_ack_i)
                 st_d = dec.snoop ? ST_SNP : (dec.rewrite ? ST_WR : ST_RSP);
      ST_SNP:  if (snp_ack_i) st_d = dec_q.rewrite ? ST_WR : ST_RSP;
      ST_WR:   if (mem_ack_i) st_d = ST_RSP;
      ST_RSP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      remote_q <= 1'b0;
      hint_q   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      dec_q    <= '0;
      cnt_q    <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid_i) begin
        remote_q <= req_remote_i;
        hint_q   <= req_shared_i;
        addr_q   <= req_addr_i;
      end
      if (rd_done) begin
        data_q <= mem_rdata_i;
        dec_q  <= dec;
      end
      if (st_q == ST_WR && mem_ack_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req_ready_o   = (st_q == ST_IDLE);
  assign rsp_valid_o   = (st_q == ST_RSP);
  assign rsp_remote_o  = remote_q;
  assign rsp_state_o   = dec_q.grant;
  assign rsp_data_o    = data_q;
  assign snp_valid_o   = (st_q == ST_SNP);
  assign snp_addr_o    = addr_q;
  assign mem_req_o     = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o      = (st_q == ST_WR);
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = data_q;
  assign mem_wdir_o    = (st_q == ST_WR);
  assign rewrite_cnt_o = cnt_q;
endmodule

// File: rtl/hadir_chk.sv
module hadir_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              snp_valid_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_wdir_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [CNT_W-1:0]  rewrite_cnt_o
);
  // R8
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || snp_valid_o || mem_req_o) |-> !req_ready_o);
  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R8
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R3
  wr_dir_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdir_o);
  // R5
  snp_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_o |-> !(mem_req_o && mem_we_o));
  // R10
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rewrite_cnt_o != $past(rewrite_cnt_o)) |->
      ($past(mem_req_o && mem_we_o && mem_ack_i) &&
       rewrite_cnt_o == $past(rewrite_cnt_o) + 1'b1));
endmodule

bind hadir_top hadir_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_hadir_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_ready_o   (req_ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .snp_valid_o   (snp_valid_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_wdir_o    (mem_wdir_o),
  .mem_ack_i     (mem_ack_i),
  .mem_addr_o    (mem_addr_o),
  .rewrite_cnt_o (rewrite_cnt_o)
);

// File: tb/test_hadir_top.sv
`timescale 1ns/1ps
module test_hadir_top;
  localparam int AW = 8;
  localparam int LW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_remote = 1'b0, req_shared = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rsp_valid, rsp_remote;
  logic [1:0]    rsp_state;
  logic [LW-1:0] rsp_data;
  logic          snp_valid, snp_ack = 1'b0;
  logic [AW-1:0] snp_addr;
  logic          mem_req, mem_we, mem_wdir, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_wdata, mem_rdata;
  logic          mem_rdir;
  logic [CW-1:0] rcnt;

  always #2 clk = ~clk;

  hadir_top #(.ADDR_W(AW), .LINE_W(LW), .DEPTH(4), .CNT_W(CW)) i_hadir_top (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_remote_i(req_remote),
    .req_addr_i(req_addr), .req_shared_i(req_shared),
    .rsp_valid_o(rsp_valid), .rsp_remote_o(rsp_remote), .rsp_state_o(rsp_state),
    .rsp_data_o(rsp_data),
    .snp_valid_o(snp_valid), .snp_addr_o(snp_addr), .snp_ack_i(snp_ack),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_wdir_o(mem_wdir), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .mem_rdir_i(mem_rdir), .rewrite_cnt_o(rcnt)
  );

  function automatic logic [LW-1:0] line_of(logic [AW-1:0] a);
    return {a, ~a, a ^ 8'h5A, 8'hC3};
  endfunction

  // memory and snoop responder models
  logic [LW-1:0] mdata [256];
  logic          mdir  [256];
  logic          booted = 1'b0;
  int            wr_total = 0, snp_total = 0;
  logic [LW-1:0] last_wdata = '0;
  logic          last_wdir = 1'b0;
  logic [AW-1:0] last_snp_addr = '0;

  assign mem_rdata = mdata[mem_addr];
  assign mem_rdir  = mdir[mem_addr];

  always @(posedge clk) begin
    if (!booted) begin
      for (int a = 0; a < 256; a++) begin
        mdata[a] <= line_of(a[AW-1:0]);
        mdir[a]  <= a[6];
      end
      booted <= 1'b1;
    end
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && mem_we && !mem_ack) begin
      mdata[mem_addr] <= mem_wdata;
      mdir[mem_addr]  <= mem_wdir;
      last_wdata      <= mem_wdata;
      last_wdir       <= mem_wdir;
      wr_total        <= wr_total + 1;
    end
    snp_ack <= snp_valid && !snp_ack;
    if (snp_valid && !snp_ack) begin
      snp_total     <= snp_total + 1;
      last_snp_addr <= snp_addr;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  logic [1:0]    got_st;
  logic [LW-1:0] got_data;
  logic          got_rem, ready_low_ok;
  int            got_wr, got_snp;

  task automatic do_req(logic rem, logic hint, logic [AW-1:0] a);
    int w0, s0, n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    w0 = wr_total; s0 = snp_total;
    req_valid = 1'b1; req_remote = rem; req_shared = hint; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    ready_low_ok = 1'b1;
    n = 0;
    while (!rsp_valid && n < 1000) begin
      if (req_ready) ready_low_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    if (req_ready) ready_low_ok = 1'b0;
    got_st = rsp_state; got_data = rsp_data; got_rem = rsp_remote;
    got_wr = wr_total - w0; got_snp = snp_total - s0;
  endtask

  typedef struct packed {
    logic          rem;
    logic          hint;
    logic [AW-1:0] addr;
    logic [1:0]    st;
    logic          wr;
    logic          snp;
    logic [3:0]    rq;
  } vec_t;

  // index = addr[1:0]; lines with addr[6]=1 start with the directory bit set
  localparam vec_t VEC [14] = '{
    '{1'b0, 1'b0, 8'h01, 2'd2, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 8'h01, 2'd1, 1'b0, 1'b1, 4'd5},  // R5 downgrade
    '{1'b1, 1'b0, 8'h01, 2'd1, 1'b0, 1'b0, 4'd5},  // R5 local S
    '{1'b1, 1'b1, 8'h02, 2'd1, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 1'b0, 8'h02, 2'd2, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b1, 1'b0, 8'h02, 2'd2, 1'b0, 1'b0, 4'd4},  // R4 bit now set
    '{1'b1, 1'b0, 8'h41, 2'd2, 1'b0, 1'b0, 4'd4},  // R4 preset, R9 tag miss
    '{1'b0, 1'b0, 8'h05, 2'd2, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 8'h09, 2'd2, 1'b1, 1'b0, 4'd9},  // R9 same index, other tag
    '{1'b0, 1'b0, 8'h42, 2'd1, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b1, 1'b1, 8'h05, 2'd1, 1'b0, 1'b1, 4'd6},  // R6 hint with local E
    '{1'b0, 1'b0, 8'h03, 2'd2, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b1, 8'h03, 2'd1, 1'b0, 1'b1, 4'd6},  // R6
    '{1'b1, 1'b0, 8'h42, 2'd1, 1'b0, 1'b0, 4'd5}   // R5 local S
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(req_ready === 1'b1, "R1", "ready", req_ready, 1);
    chk(rsp_valid === 1'b0 && mem_req === 1'b0 && snp_valid === 1'b0, "R1", "idle outs",
        {rsp_valid, mem_req, snp_valid}, 0);
    chk(rcnt === '0, "R1", "cnt", rcnt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 14; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].rq);
      do_req(VEC[i].rem, VEC[i].hint, VEC[i].addr);
      chk(got_st == VEC[i].st, rq, $sformatf("v%0d grant", i), got_st, VEC[i].st);
      chk(got_wr == int'(VEC[i].wr), rq, $sformatf("v%0d writes", i), got_wr, VEC[i].wr);
      chk(got_snp == int'(VEC[i].snp), rq, $sformatf("v%0d snoops", i), got_snp, VEC[i].snp);
      // R8
      chk(got_data == line_of(VEC[i].addr), "R8", $sformatf("v%0d data", i), got_data,
          line_of(VEC[i].addr));
      chk(got_rem == VEC[i].rem && ready_low_ok, "R8", $sformatf("v%0d rem/ready", i),
          {got_rem, ready_low_ok}, {VEC[i].rem, 1'b1});
      if (VEC[i].wr)  // R3 full line rewritten unchanged with bit set
        chk(last_wdata == line_of(VEC[i].addr) && last_wdir, "R3", "rewrite content",
            last_wdata, line_of(VEC[i].addr));
      if (VEC[i].snp)
        chk(last_snp_addr == VEC[i].addr, "R5", "snoop addr", last_snp_addr, VEC[i].addr);
    end
    // R10
    chk(rcnt == 16'd2, "R10", "cnt after table", rcnt, 2);

    // reset mid-activity clears table and counter
    do_req(1'b0, 1'b0, 8'h07);
    chk(got_st == 2'd2, "R2", "local 07", got_st, 2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(rcnt === '0 && req_ready === 1'b1, "R1", "mid reset", {rcnt, req_ready}, 1);
    rst_n = 1'b1;
    do_req(1'b1, 1'b0, 8'h07);
    // R1 table cleared: no snoop, exclusive with rewrite
    chk(got_snp == 0 && got_st == 2'd2 && got_wr == 1, "R1", "post-reset table",
        {got_snp[3:0], got_st, got_wr[3:0]}, {4'd0, 2'd2, 4'd1});
    chk(rcnt == 16'd1, "R10", "cnt after reset", rcnt, 1);
    // R4 repeat on now-set bit
    do_req(1'b1, 1'b0, 8'h07);
    chk(got_wr == 0 && rcnt == 16'd1, "R4", "no second rewrite", got_wr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule